// File: doc/BRIEF.md
# Synchronous Serial Port Register Front-End

This block is the bus-facing side of a synchronous serial master. A processor reaches it through a simple 32-bit register port: an address, read and write strobes, and data in both directions. Words the processor writes to the data register queue in an eight-entry transmit FIFO. Words that come back from the line queue in an eight-entry receive FIFO, which the processor drains by reading the same data register. Each FIFO word is up to 16 bits wide.

A separate shift engine, outside this block, does the serial transfer. It takes the oldest transmit word through a valid/pop handshake and returns each received word through a push strobe. The front-end also holds the configuration, control and clock-divider registers. It derives the status flags and level interrupts from the two FIFO fill counts, keeps a sticky receive-overrun flag, and drives one masked interrupt line. A read-only window of identification bytes sits at the top of the 4 KB space.

Top module: `sspfe_top`

## Requirements
- R1: After reset both FIFOs are empty and the interrupt mask is zero. The status register reads 0x03, the raw interrupt register reads 0x08 and `irq` is low.
- R2: The status register (0x0C) has these bits: bit0 = transmit FIFO empty, bit1 = transmit FIFO not full, bit2 = receive FIFO not empty, bit3 = receive FIFO holds 8 words, bit4 = busy (transmit FIFO not empty).
- R3: A write to the data register (0x08) pushes the low (frame[3:0]+1) bits of the write data into the transmit FIFO. The frame register sits at 0x00. When the transmit FIFO already holds 8 words, the write is dropped.
- R4: A read of the data register returns the oldest receive word and removes it, so words come out in arrival order. With the receive FIFO empty, the read returns 0 and changes nothing.
- R5: Raw interrupt register (0x18): bit2 is set while the receive fill is 4 or more, and bit3 is set while the transmit fill is 4 or less. The masked register (0x1C) reads raw AND mask, where the mask register is at 0x14. `irq` is high exactly when that AND is non-zero.
- R6: A receive push from the engine while the receive FIFO holds 8 words is dropped and sets raw bit0 (overrun). A write to 0x20 clears raw bits 0 and 1 where the written bit is 1, and it has no effect on bits 2 and 3.
- R7: `tx_valid` is high only when control bit1 (enable, register 0x04) is set, the transmit FIFO is not empty and the receive FIFO is not full. `tx_word` is the oldest transmit word, and `tx_pop` removes it. Received words are masked to the frame size.
- R8: Reads from 0xFE0 through 0xFFC return, one per word, the bytes 0x22, 0x10, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R9: The frame register reads back 16 bits and the control register reads back 4 bits. The clock-divider register (0x10) keeps only bits 7:0. The register at 0x24 reads 0 and ignores writes.
- R10: An access to an offset outside the map, or to an address that is not word-aligned, reads 0 and writes nothing. `bus_err` is high for exactly the one cycle after such an access.
- R11: A data-register write and an engine pop in the same cycle both take effect. A data-register read and an engine push in the same cycle also both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle `bus_rd` is high |
| bus_err | output | 1 | One-cycle pulse after an undecoded access |
| irq | output | 1 | Combined masked interrupt |
| eng_enable | output | 1 | Control enable bit for the engine |
| eng_size | output | 4 | Frame size field (bits per word minus one) |
| tx_valid | output | 1 | A transmit word may be taken |
| tx_word | output | 16 | Oldest transmit word |
| tx_pop | input | 1 | Engine takes `tx_word` |
| rx_push | input | 1 | Engine delivers a received word |
| rx_word | input | 16 | Received word |
| rx_ready | output | 1 | Receive FIFO has room |

## Verification
Both FIFOs are touched from two sides, so the processor and the engine can act on the same FIFO in the same cycle. The bench provokes this on purpose. It writes the data register while the engine pops the transmit FIFO, and then reads the data register while the engine pushes a new receive word. It judges both cases by the status fill flags and by the order of the words read back afterwards: the word written in the shared cycle and the word pushed in the shared cycle must each appear later, in order. The overrun path is also driven against a full receive FIFO, and the stall rule is checked while receive words are still waiting to be read.

// File: rtl/sspfe_pkg.sv
package sspfe_pkg;

    localparam int unsigned ADDR_W = 12;
    localparam int unsigned WORD_W = 16;

    localparam logic [ADDR_W-1:0] OFS_FRAME = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_CTRL  = 12'h004;
    localparam logic [ADDR_W-1:0] OFS_DATA  = 12'h008;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 12'h00C;
    localparam logic [ADDR_W-1:0] OFS_DIV   = 12'h010;
    localparam logic [ADDR_W-1:0] OFS_MASK  = 12'h014;
    localparam logic [ADDR_W-1:0] OFS_RAW   = 12'h018;
    localparam logic [ADDR_W-1:0] OFS_MSKD  = 12'h01C;
    localparam logic [ADDR_W-1:0] OFS_CLR   = 12'h020;
    localparam logic [ADDR_W-1:0] OFS_DMA   = 12'h024;
    localparam logic [ADDR_W-1:0] OFS_IDWIN = 12'hFE0;

    typedef enum logic [3:0] {
        RG_FRAME, RG_CTRL, RG_DATA, RG_STAT, RG_DIV, RG_MASK,
        RG_RAW, RG_MSKD, RG_CLR, RG_DMA, RG_ID, RG_NONE
    } reg_sel_e;

    // Status word: packed MSB first, so busy lands on bit 4.
    typedef struct packed {
        logic busy;
        logic rx_full;
        logic rx_nempty;
        logic tx_nfull;
        logic tx_empty;
    } stat_t;

    // Raw interrupt word: tx level on bit 3, overrun on bit 0.
    typedef struct packed {
        logic tx_lvl;
        logic rx_lvl;
        logic rx_tmo;
        logic rx_ovr;
    } irq_t;

    function automatic reg_sel_e decode_ofs(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        if (a[1:0] != 2'b00) begin
            s = RG_NONE;
        end else if (a >= OFS_IDWIN) begin
            s = RG_ID;
        end else begin
            case (a)
                OFS_FRAME: s = RG_FRAME;
                OFS_CTRL:  s = RG_CTRL;
                OFS_DATA:  s = RG_DATA;
                OFS_STAT:  s = RG_STAT;
                OFS_DIV:   s = RG_DIV;
                OFS_MASK:  s = RG_MASK;
                OFS_RAW:   s = RG_RAW;
                OFS_MSKD:  s = RG_MSKD;
                OFS_CLR:   s = RG_CLR;
                OFS_DMA:   s = RG_DMA;
                default:   s = RG_NONE;
            endcase
        end
        return s;
    endfunction

    function automatic logic [7:0] id_byte(input logic [2:0] idx);
        logic [7:0] b;
        case (idx)
            3'd0: b = 8'h22;
            3'd1: b = 8'h10;
            3'd2: b = 8'h04;
            3'd3: b = 8'h00;
            3'd4: b = 8'h0D;
            3'd5: b = 8'hF0;
            3'd6: b = 8'h05;
            default: b = 8'hB1;
        endcase
        return b;
    endfunction

    // Keep the low (sz+1) bits of a word.
    function automatic logic [WORD_W-1:0] size_mask(input logic [3:0] sz);
        logic [WORD_W:0] m;
        m = ({{WORD_W{1'b0}}, 1'b1} << ({1'b0, sz} + 5'd1)) - {{WORD_W{1'b0}}, 1'b1};
        return m[WORD_W-1:0];
    endfunction

endpackage

// File: rtl/sspfe_fifo.sv
module sspfe_fifo #(
    parameter int unsigned W     = 16,
    parameter int unsigned DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push,
    input  logic [W-1:0]               pdata,
    input  logic                       pop,
    output logic [W-1:0]               head,
    output logic [$clog2(DEPTH+1)-1:0] cnt,
    output logic                       full,
    output logic                       empty
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH+1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wptr, rptr;
    logic [CNT_W-1:0] cnt_q;
    logic             do_push, do_pop;

    assign full    = (cnt_q == CNT_W'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rptr];
    assign cnt     = cnt_q;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) begin
                mem[wptr] <= pdata;
                wptr      <= bump(wptr);
            end
            if (do_pop) begin
                rptr <= bump(rptr);
            end
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end
endmodule

// File: rtl/sspfe_irq.sv
module sspfe_irq
    import sspfe_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned CNT_W = $clog2(DEPTH+1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] tx_cnt,
    input  logic [CNT_W-1:0] rx_cnt,
    input  logic             ovr_evt,
    input  logic             clr_we,
    input  logic [1:0]       clr_bits,
    input  logic             mask_we,
    input  logic [3:0]       mask_in,
    output irq_t             raw,
    output logic [3:0]       mask,
    output logic             irq_o
);
    localparam logic [CNT_W-1:0] LVL = CNT_W'(DEPTH / 2);

    logic       ovr_q, tmo_q;
    logic [3:0] mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ovr_q  <= 1'b0;
            tmo_q  <= 1'b0;
            mask_q <= '0;
        end else begin
            if (mask_we) mask_q <= mask_in;
            if (clr_we && clr_bits[1]) tmo_q <= 1'b0;
            if (ovr_evt) begin
                ovr_q <= 1'b1;
            end else if (clr_we && clr_bits[0]) begin
                ovr_q <= 1'b0;
            end
        end
    end

    always_comb begin
        raw.tx_lvl = (tx_cnt <= LVL);
        raw.rx_lvl = (rx_cnt >= LVL);
        raw.rx_tmo = tmo_q;
        raw.rx_ovr = ovr_q;
    end

    assign mask  = mask_q;
    assign irq_o = |(raw & mask_q);
endmodule

// File: rtl/sspfe_top.sv
module sspfe_top
    import sspfe_pkg::*;
#(
    parameter int unsigned DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_err,
    output logic              irq,
    output logic              eng_enable,
    output logic [3:0]        eng_size,
    output logic              tx_valid,
    output logic [WORD_W-1:0] tx_word,
    input  logic              tx_pop,
    input  logic              rx_push,
    input  logic [WORD_W-1:0] rx_word,
    output logic              rx_ready
);
    localparam int unsigned CNT_W = $clog2(DEPTH+1);

    reg_sel_e          sel;
    logic [15:0]       frame_q;
    logic [3:0]        ctrl_q;
    logic [7:0]        div_q;
    logic              err_q;
    logic [WORD_W-1:0] wmask;

    logic [CNT_W-1:0]  tx_cnt, rx_cnt;
    logic              tx_full, tx_empty, rx_full, rx_empty;
    logic [WORD_W-1:0] rx_head;
    logic              wr_data, rd_data;
    irq_t              raw_s;
    logic [3:0]        raw_bits;
    logic [3:0]        mask_q;
    stat_t             stat;

    assign sel     = decode_ofs(bus_addr);
    assign wmask   = size_mask(frame_q[3:0]);
    assign wr_data = bus_wr && (sel == RG_DATA);
    assign rd_data = bus_rd && (sel == RG_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_q <= '0;
            ctrl_q  <= '0;
            div_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            err_q <= (bus_wr || bus_rd) && (sel == RG_NONE);
            if (bus_wr) begin
                case (sel)
                    RG_FRAME: frame_q <= bus_wdata[15:0];
                    RG_CTRL:  ctrl_q  <= bus_wdata[3:0];
                    RG_DIV:   div_q   <= bus_wdata[7:0];
                    default:  ;
                endcase
            end
        end
    end

    sspfe_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_txq (
        .clk   (clk),
        .rst   (rst),
        .push  (wr_data),
        .pdata (bus_wdata[WORD_W-1:0] & wmask),
        .pop   (tx_valid && tx_pop),
        .head  (tx_word),
        .cnt   (tx_cnt),
        .full  (tx_full),
        .empty (tx_empty)
    );

    sspfe_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_rxq (
        .clk   (clk),
        .rst   (rst),
        .push  (rx_push),
        .pdata (rx_word & wmask),
        .pop   (rd_data),
        .head  (rx_head),
        .cnt   (rx_cnt),
        .full  (rx_full),
        .empty (rx_empty)
    );

    sspfe_irq #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_irq (
        .clk      (clk),
        .rst      (rst),
        .tx_cnt   (tx_cnt),
        .rx_cnt   (rx_cnt),
        .ovr_evt  (rx_push && rx_full),
        .clr_we   (bus_wr && (sel == RG_CLR)),
        .clr_bits (bus_wdata[1:0]),
        .mask_we  (bus_wr && (sel == RG_MASK)),
        .mask_in  (bus_wdata[3:0]),
        .raw      (raw_s),
        .mask     (mask_q),
        .irq_o    (irq)
    );

    assign raw_bits = raw_s;

    always_comb begin
        stat.busy      = !tx_empty;
        stat.rx_full   = rx_full;
        stat.rx_nempty = !rx_empty;
        stat.tx_nfull  = !tx_full;
        stat.tx_empty  = tx_empty;
    end

    always_comb begin
        bus_rdata = '0;
        case (sel)
            RG_FRAME: bus_rdata = {16'b0, frame_q};
            RG_CTRL:  bus_rdata = {28'b0, ctrl_q};
            RG_DATA:  bus_rdata = rx_empty ? '0 : {{(32-WORD_W){1'b0}}, rx_head};
            RG_STAT:  bus_rdata = {27'b0, stat};
            RG_DIV:   bus_rdata = {24'b0, div_q};
            RG_MASK:  bus_rdata = {28'b0, mask_q};
            RG_RAW:   bus_rdata = {28'b0, raw_bits};
            RG_MSKD:  bus_rdata = {28'b0, raw_bits & mask_q};
            RG_ID:    bus_rdata = {24'b0, id_byte(bus_addr[4:2])};
            default:  bus_rdata = '0;
        endcase
    end

    assign bus_err    = err_q;
    assign eng_enable = ctrl_q[1];
    assign eng_size   = frame_q[3:0];
    assign rx_ready   = !rx_full;
    assign tx_valid   = ctrl_q[1] && !tx_empty && !rx_full;
endmodule

// File: rtl/sspfe_chk.sv
module sspfe_chk
    import sspfe_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned CNT_W = $clog2(DEPTH+1)
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [31:0]       bus_rdata,
    input logic              bus_err,
    input logic              irq,
    input logic              eng_enable,
    input logic              tx_valid,
    input logic              tx_pop,
    input logic              rx_push,
    input logic [CNT_W-1:0]  tx_cnt,
    input logic [CNT_W-1:0]  rx_cnt,
    input logic [3:0]        raw_bits,
    input logic [3:0]        mask_q
);
    // R1: reset leaves both queues empty and the mask cleared
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (tx_cnt == '0 && rx_cnt == '0 && mask_q == '0));

    // R3: fill never exceeds the depth
    p_tx_bound_r3: assert property (@(posedge clk) disable iff (rst)
        tx_cnt <= CNT_W'(DEPTH));

    // R3: a write into a full transmit queue with no pop leaves it full
    p_drop_full_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_DATA && tx_cnt == CNT_W'(DEPTH) && !(tx_valid && tx_pop))
        |=> tx_cnt == CNT_W'(DEPTH));

    // R4: reading an empty receive queue returns zero
    p_empty_read_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == OFS_DATA && rx_cnt == '0) |-> bus_rdata == 32'h0);

    // R5: no mask bits means no interrupt
    p_irq_masked_r5: assert property (@(posedge clk) disable iff (rst)
        (mask_q == 4'h0) |-> !irq);

    // R5: a non-zero masked read implies the line is high
    p_irq_line_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == OFS_MSKD && bus_rdata != 32'h0) |-> irq);

    // R6: a push into a full receive queue raises overrun
    p_overrun_r6: assert property (@(posedge clk) disable iff (rst)
        (rx_push && rx_cnt == CNT_W'(DEPTH)) |=> raw_bits[0]);

    // R7: the engine is offered a word only when it may be moved
    p_stall_r7: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> (eng_enable && rx_cnt < CNT_W'(DEPTH) && tx_cnt != '0));

    // R8: first identification byte
    p_id_first_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == OFS_IDWIN) |-> bus_rdata == 32'h22);

    // R10: an error pulse always follows some access
    p_err_cause_r10: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> $past(bus_rd || bus_wr));
endmodule

bind sspfe_top sspfe_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_rdata  (bus_rdata),
    .bus_err    (bus_err),
    .irq        (irq),
    .eng_enable (eng_enable),
    .tx_valid   (tx_valid),
    .tx_pop     (tx_pop),
    .rx_push    (rx_push),
    .tx_cnt     (tx_cnt),
    .rx_cnt     (rx_cnt),
    .raw_bits   (raw_bits),
    .mask_q     (mask_q)
);

// File: tb/sim_sspfe_top.sv
`timescale 1ns/1ps
module sim_sspfe_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err, irq, eng_enable, tx_valid, rx_ready;
    logic [3:0]  eng_size;
    logic [15:0] tx_word;
    logic        tx_pop = 1'b0, rx_push = 1'b0;
    logic [15:0] rx_word = '0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    sspfe_top u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err), .irq(irq),
        .eng_enable(eng_enable), .eng_size(eng_size), .tx_valid(tx_valid),
        .tx_word(tx_word), .tx_pop(tx_pop), .rx_push(rx_push), .rx_word(rx_word),
        .rx_ready(rx_ready)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: compares each read against the scoreboard queue.
    always @(negedge clk) begin
        if (bus_rd) begin
            if (exp_q.size() == 0) begin
                chk(32'h1, 32'h0, "scoreboard underrun");
            end else begin
                chk(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    // Driver: one bus/engine cycle, expected read data goes to the scoreboard.
    task automatic step(input logic wr, input logic rd, input logic [11:0] a,
                        input logic [31:0] d, input logic pop, input logic push,
                        input logic [15:0] rw, input logic [31:0] exp, input string tag);
        @(posedge clk); #1;
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
        tx_pop = pop; rx_push = push; rx_word = rw;
        if (rd) begin
            exp_q.push_back(exp);
            tag_q.push_back(tag);
        end
        @(posedge clk); #1;
        bus_wr = 0; bus_rd = 0; tx_pop = 0; rx_push = 0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        step(1, 0, a, d, 0, 0, 16'h0, 32'h0, "");
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
        step(0, 1, a, 32'h0, 0, 0, 16'h0, exp, tag);
    endtask

    // Engine moves one word: checks the offered word, then loops it back with junk high bits.
    task automatic xfer(input logic [15:0] w, input string tag);
        @(negedge clk);
        chk({31'b0, tx_valid}, 32'h1, {tag, " valid"});
        chk({16'b0, tx_word}, {16'b0, w}, {tag, " word"});
        step(0, 0, 12'h0, 32'h0, 1, 1, 16'h0300 | w, 32'h0, "");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;

        // R1 reset state
        rd(12'h00C, 32'h03, "R1 status after reset");
        rd(12'h018, 32'h08, "R1 raw after reset");
        rd(12'h014, 32'h00, "R1 mask after reset");
        @(negedge clk); chk({31'b0, irq}, 32'h0, "R1 irq after reset");

        // R9 read-back, R3 masking, R7 disabled
        wr(12'h000, 32'h0000_FF07);
        rd(12'h000, 32'h0000_FF07, "R9 frame readback");
        wr(12'h008, 32'h0000_01A5);
        @(negedge clk); chk({31'b0, tx_valid}, 32'h0, "R7 disabled no valid");
        rd(12'h00C, 32'h12, "R2 one tx word");
        for (int i = 1; i < 8; i++) wr(12'h008, i);
        rd(12'h00C, 32'h10, "R2 tx full");
        wr(12'h008, 32'h99);
        rd(12'h018, 32'h00, "R5 tx fill 8");

        // R7 enable and engine transfers
        wr(12'h004, 32'h2);
        rd(12'h004, 32'h2, "R9 ctrl readback");
        xfer(16'h00A5, "R3 first word masked");
        xfer(16'h0001, "R7 xfer1");
        xfer(16'h0002, "R7 xfer2");
        rd(12'h018, 32'h00, "R5 tx5 rx3 no level");
        xfer(16'h0003, "R7 xfer3");
        rd(12'h018, 32'h0C, "R5 tx4 rx4 both levels");
        wr(12'h014, 32'h4);
        @(negedge clk); chk({31'b0, irq}, 32'h1, "R5 irq rx level");
        rd(12'h01C, 32'h04, "R5 masked read");
        wr(12'h014, 32'h2);
        @(negedge clk); chk({31'b0, irq}, 32'h0, "R5 irq masked off");
        for (int i = 4; i < 8; i++) xfer(16'(i), "R7 xfer rest");
        rd(12'h00C, 32'h0F, "R2 tx empty rx full");
        @(negedge clk); chk({31'b0, rx_ready}, 32'h0, "R7 rx_ready low");

        // R6 overrun and clear
        step(0, 0, 12'h0, 32'h0, 0, 1, 16'h0077, 32'h0, "");
        rd(12'h018, 32'h0D, "R6 overrun set");
        wr(12'h014, 32'h1);
        @(negedge clk); chk({31'b0, irq}, 32'h1, "R6 irq on overrun");
        wr(12'h020, 32'hF);
        rd(12'h018, 32'h0C, "R6 clear only error bits");
        @(negedge clk); chk({31'b0, irq}, 32'h0, "R6 irq after clear");

        // R7 stall while receive queue full
        wr(12'h008, 32'h55);
        @(negedge clk); chk({31'b0, tx_valid}, 32'h0, "R7 stall rx full");
        rd(12'h008, 32'hA5, "R4 oldest first");
        xfer(16'h0055, "R7 resume after read");
        for (int i = 1; i < 8; i++) rd(12'h008, i, "R4 order");
        rd(12'h008, 32'h55, "R4 last word");
        rd(12'h008, 32'h00, "R4 empty read zero");
        rd(12'h00C, 32'h03, "R4 empty read no change");

        // R11 simultaneous actions
        wr(12'h008, 32'h11);
        wr(12'h008, 32'h22);
        step(1, 0, 12'h008, 32'h33, 1, 1, 16'h0011, 32'h0, "");
        rd(12'h00C, 32'h16, "R11 write with pop");
        step(0, 1, 12'h008, 32'h0, 1, 1, 16'h0022, 32'h11, "R11 read with push");
        rd(12'h008, 32'h22, "R11 pushed word kept");
        xfer(16'h0033, "R11 written word kept");
        rd(12'h008, 32'h33, "R11 last word");
        rd(12'h00C, 32'h03, "R11 all empty");

        // R8 identification window
        rd(12'hFE0, 32'h22, "R8 id0");
        rd(12'hFE4, 32'h10, "R8 id1");
        rd(12'hFE8, 32'h04, "R8 id2");
        rd(12'hFEC, 32'h00, "R8 id3");
        rd(12'hFF0, 32'h0D, "R8 id4");
        rd(12'hFF4, 32'hF0, "R8 id5");
        rd(12'hFF8, 32'h05, "R8 id6");
        rd(12'hFFC, 32'hB1, "R8 id7");

        // R9 divider and DMA register
        wr(12'h010, 32'h1234);
        rd(12'h010, 32'h34, "R9 divider low byte");
        wr(12'h024, 32'hFF);
        rd(12'h024, 32'h00, "R9 dma reads zero");
        @(negedge clk); chk({31'b0, bus_err}, 32'h0, "R10 no error on mapped");

        // R10 undecoded access
        wr(12'h040, 32'hFFFF);
        @(negedge clk); chk({31'b0, bus_err}, 32'h1, "R10 error pulse");
        @(negedge clk); chk({31'b0, bus_err}, 32'h0, "R10 pulse one cycle");
        wr(12'h001, 32'h0003);
        rd(12'h000, 32'h0000_FF07, "R10 unaligned write ignored");
        rd(12'h040, 32'h00, "R10 undecoded read zero");

        repeat (3) @(posedge clk);
        finish_run();
    end
endmodule